// File: doc/BRIEF.md
# Serial Bit-Rate Generator with Prescaler

This block produces the timing enables for one serial channel. A free-running prescaler divides the peripheral clock by 1, 4, 16 or 64. An 8-bit rate register N then divides that prescaled rate by N+1. A small phase counter turns the resulting base rate into the enables the channel needs. In asynchronous mode these are a bit-period tick and a 16x oversampling tick for mid-bit sampling by a receiver. In clocked synchronous mode they are a bit-period tick and a serial clock that toggles every half bit. Every enable is a single-cycle pulse in the peripheral clock domain, so shifters elsewhere can use them as clock enables.

The CPU writes and reads the rate register at any time through a plain write strobe and a read data bus. Writing the rate register resets the generator's phase, and so does changing the clock source or the mode. The first tick after such a change comes a full new period later. While the standby input is high, the generator is silent and the rate register is held at all-ones. Each channel instantiates its own copy, so two channels can run at different rates.

Top module: `brg_top`

## Requirements
- R1: After reset, rd_data reads 0xFF, bit_tick, ovs_tick and sclk_edge are low, and sclk is high.
- R2: A write (wr_en high while stby is low) stores wr_data, and rd_data shows it from the next cycle on, even while ticks are being produced. Without a write or standby, rd_data holds its value.
- R3: src_sel code s (0 to 3) sets the prescale factor to 4^s. This factor multiplies every period below.
- R4: In asynchronous mode (sync_mode = 0), bit_tick pulses once every 32 * 4^s * (N+1) clocks.
- R5: In asynchronous mode, ovs_tick pulses once every 2 * 4^s * (N+1) clocks, and every 16th pulse falls in the same cycle as bit_tick. In synchronous mode, ovs_tick stays low.
- R6: In synchronous mode (sync_mode = 1), bit_tick pulses once every 4 * 4^s * (N+1) clocks. sclk idles high and falls half a bit period into each bit. It rises in the same cycle as bit_tick, and sclk_edge pulses with each toggle. In asynchronous mode, sclk stays high and sclk_edge stays low.
- R7: Three events sample the reload: a write, a change of src_sel, and a change of sync_mode. After the clock edge that samples one of them, the first bit_tick is high in the cycle that follows exactly P further clock edges, where P is the bit period of the new setting. No bit_tick comes earlier.
- R8: While stby is high, rd_data reads 0xFF from the next cycle on, writes are ignored, no tick pulses occur and sclk is high. After the last edge that sampled stby high, the first bit_tick follows P edges later.
- R9: bit_tick, ovs_tick and sclk_edge are each never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stby | input | 1 | Standby: silences the generator and forces the rate register to all-ones |
| sync_mode | input | 1 | 0 = asynchronous, 1 = clocked synchronous |
| src_sel | input | 2 | Prescaler select s, divide by 4^s |
| wr_en | input | 1 | Rate register write strobe |
| wr_data | input | 8 | Rate register write data N |
| rd_data | output | 8 | Rate register read data |
| bit_tick | output | 1 | One pulse per bit period |
| ovs_tick | output | 1 | Oversampling enable, 16 per bit, asynchronous mode only |
| sclk | output | 1 | Serial clock level, synchronous mode only, idles high |
| sclk_edge | output | 1 | Pulse on each sclk toggle |

## Verification
The bench builds the block with its default parameters: an 8-bit rate register, a 2-bit source select, a divide of 32 per bit in asynchronous mode, a divide of 2 per oversample and a divide of 4 per synchronous bit. At the largest prescale a full-scale rate gives periods of half a million clocks. Random cases are therefore limited to periods of at most 2048 clocks by choosing N from the prescale. Directed cases still cover N = 0 and N = 255 at the smallest prescale, every source code, and reloads caused by each of write, source change, mode change and standby release. Exact first-tick latency and tick spacing are checked cycle by cycle.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } brg_mode_e;

  typedef struct packed {
    logic bit_t;
    logic ovs_t;
    logic half_t;
  } brg_ticks_t;

endpackage

// File: rtl/brg_ratereg.sv
module brg_ratereg #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_q
);

  logic [RATE_W-1:0] rate_d;

  always_comb begin
    rate_d = rate_q;
    if (stby)       rate_d = '1;
    else if (wr_en) rate_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= '1;
    else        rate_q <= rate_d;
  end

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int SEL_W    = 2,
  parameter int STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_en
);

  localparam int NSEL  = 1 << SEL_W;
  localparam int SPAN  = STEP_LOG * (NSEL - 1);
  localparam int CNT_W = (SPAN > 0) ? SPAN : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSEL-1:0]  hit;

  // tap g fires when the low g*STEP_LOG bits are all ones
  assign hit[0] = 1'b1;
  for (genvar g = 1; g < NSEL; g++) begin : g_tap
    assign hit[g] = &cnt_q[g*STEP_LOG-1:0];
  end

  assign pre_en = ~clear & hit[sel];

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              pre_en,
  input  logic [RATE_W-1:0] rate,
  output logic              base_en
);

  logic [RATE_W-1:0] cnt_q, cnt_d;

  assign base_en = pre_en & (cnt_q == rate);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (base_en) cnt_d = '0;
    else if (pre_en)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/brg_phase.sv
module brg_phase
  import brg_pkg::*;
#(
  parameter int ASYNC_LOG = 5,
  parameter int OVS_LOG   = 1,
  parameter int SYNC_LOG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  brg_mode_e  mode,
  input  logic       base_en,
  output brg_ticks_t ticks_q,
  output logic       sclk_q
);

  localparam int POST_W   = (ASYNC_LOG > SYNC_LOG) ? ASYNC_LOG : SYNC_LOG;
  localparam int HALF_LOG = SYNC_LOG - 1;

  logic [POST_W-1:0] post_q, post_d;
  brg_ticks_t        ticks_d;
  logic              sclk_d;

  always_comb begin
    post_d  = post_q;
    ticks_d = '0;
    if (clear) begin
      post_d = '0;
    end else if (base_en) begin
      post_d = post_q + 1'b1;
      if (mode == MODE_ASYNC) begin
        ticks_d.bit_t = &post_q[ASYNC_LOG-1:0];
        ticks_d.ovs_t = &post_q[OVS_LOG-1:0];
      end else begin
        ticks_d.bit_t  = &post_q[SYNC_LOG-1:0];
        ticks_d.half_t = &post_q[HALF_LOG-1:0];
      end
    end
    if (clear)               sclk_d = 1'b1;
    else if (ticks_d.half_t) sclk_d = ~sclk_q;
    else                     sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q  <= '0;
      ticks_q <= '0;
      sclk_q  <= 1'b1;
    end else begin
      post_q  <= post_d;
      ticks_q <= ticks_d;
      sclk_q  <= sclk_d;
    end
  end

endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int RATE_W    = 8,
  parameter int SEL_W     = 2,
  parameter int STEP_LOG  = 2,
  parameter int ASYNC_LOG = 5,
  parameter int OVS_LOG   = 1,
  parameter int SYNC_LOG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              sync_mode,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] wr_data,
  output logic [RATE_W-1:0] rd_data,
  output logic              bit_tick,
  output logic              ovs_tick,
  output logic              sclk,
  output logic              sclk_edge
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_s;
  logic [SEL_W-1:0]  src_q;
  brg_mode_e         mode_q, mode_in;
  logic              reload;
  logic [RATE_W-1:0] rate_q;
  logic              pre_en, base_en;
  brg_ticks_t        ticks_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign mode_in = brg_mode_e'(sync_mode);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      src_q  <= '0;
      mode_q <= MODE_ASYNC;
    end else begin
      src_q  <= src_sel;
      mode_q <= mode_in;
    end
  end

  // any change of setting restarts the whole chain from phase zero
  assign reload = stby | wr_en | (src_sel != src_q) | (mode_in != mode_q);

  brg_ratereg #(.RATE_W(RATE_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stby    (stby),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rate_q  (rate_q)
  );

  brg_prescale #(.SEL_W(SEL_W), .STEP_LOG(STEP_LOG)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clear  (reload),
    .sel    (src_q),
    .pre_en (pre_en)
  );

  brg_divider #(.RATE_W(RATE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear   (reload),
    .pre_en  (pre_en),
    .rate    (rate_q),
    .base_en (base_en)
  );

  brg_phase #(.ASYNC_LOG(ASYNC_LOG), .OVS_LOG(OVS_LOG), .SYNC_LOG(SYNC_LOG)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear   (reload),
    .mode    (mode_q),
    .base_en (base_en),
    .ticks_q (ticks_q),
    .sclk_q  (sclk)
  );

  assign rd_data   = rate_q;
  assign bit_tick  = ticks_q.bit_t;
  assign ovs_tick  = ticks_q.ovs_t;
  assign sclk_edge = ticks_q.half_t;

endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              stby,
  input logic              sync_mode,
  input logic              wr_en,
  input logic [RATE_W-1:0] wr_data,
  input logic [RATE_W-1:0] rd_data,
  input logic              bit_tick,
  input logic              ovs_tick,
  input logic              sclk,
  input logic              sclk_edge
);

  p_write_back_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !stby) |=> (rd_data == $past(wr_data)));

  p_hold_rate_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!wr_en && !stby) |=> $stable(rd_data));

  p_sync_no_ovs_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sync_mode && $past(sync_mode)) |-> !ovs_tick);

  p_bit_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sync_mode && $past(sync_mode) && bit_tick) |-> ($rose(sclk) && sclk_edge));

  p_async_idle_sclk_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sync_mode && !$past(sync_mode)) |-> (sclk && !sclk_edge));

  p_stby_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    stby |=> (!bit_tick && !ovs_tick && !sclk_edge && sclk && (rd_data == '1)));

  p_bit_single_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    bit_tick |=> !bit_tick);

  p_ovs_single_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovs_tick |=> !ovs_tick);

  p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    sclk_edge |=> !sclk_edge);

endmodule

bind brg_top brg_checker #(.RATE_W(RATE_W)) u_brg_checker (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .stby      (stby),
  .sync_mode (sync_mode),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .bit_tick  (bit_tick),
  .ovs_tick  (ovs_tick),
  .sclk      (sclk),
  .sclk_edge (sclk_edge)
);

// File: tb/test_brg_top.sv
module test_brg_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stby;
  logic       sync_mode;
  logic [1:0] src_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       bit_tick, ovs_tick, sclk, sclk_edge;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  brg_top i_brg_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby      (stby),
    .sync_mode (sync_mode),
    .src_sel   (src_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .bit_tick  (bit_tick),
    .ovs_tick  (ovs_tick),
    .sclk      (sclk),
    .sclk_edge (sclk_edge)
  );

  function automatic int bit_period(logic sm, int sel, int n);
    return (sm ? 4 : 32) * (1 << (2 * sel)) * (n + 1);
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sets mode, source and rate with one write, then watches two bit periods
  task automatic run_case(logic sm, int sel, int n);
    int p, first, second, nbit, novs, nedge, mid_lvl, end_lvl, dbl;
    logic prev_b, prev_o, prev_e;
    p = bit_period(sm, sel, n);
    @(negedge clk);
    sync_mode = sm; src_sel = sel[1:0]; wr_data = n[7:0]; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 read back", rd_data == n[7:0], rd_data, n);
    first = -1; second = -1; nbit = 0; novs = 0; nedge = 0;
    mid_lvl = -1; end_lvl = -1; dbl = 0;
    prev_b = bit_tick; prev_o = ovs_tick; prev_e = sclk_edge;
    for (int k = 1; k <= 2 * p; k++) begin
      @(negedge clk);
      if (bit_tick) begin
        nbit++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      if (ovs_tick) novs++;
      if (sclk_edge) nedge++;
      if ((bit_tick && prev_b) || (ovs_tick && prev_o) || (sclk_edge && prev_e)) dbl++;
      prev_b = bit_tick; prev_o = ovs_tick; prev_e = sclk_edge;
      if (k == p / 2) mid_lvl = int'(sclk);
      if (k == p) end_lvl = int'(sclk);
    end
    check("R7 first tick latency", first == p, first, p);
    if (sm) check("R6 R3 sync bit period", second - first == p, second - first, p);
    else    check("R4 R3 async bit period", second - first == p, second - first, p);
    check("R4 R6 bit tick count", nbit == 2, nbit, 2);
    check("R5 oversample count", novs == (sm ? 0 : 32), novs, sm ? 0 : 32);
    check("R6 sclk edge count", nedge == (sm ? 4 : 0), nedge, sm ? 4 : 0);
    check("R6 sclk mid bit", mid_lvl == (sm ? 0 : 1), mid_lvl, sm ? 0 : 1);
    check("R6 sclk at bit end", end_lvl == 1, end_lvl, 1);
    check("R9 single cycle pulses", dbl == 0, dbl, 0);
    check("R2 rate held", rd_data == n[7:0], rd_data, n);
  endtask

  // index of the first bit_tick; iteration 0 is the cycle after the next edge
  task automatic wait_first(int limit, output int first);
    first = -1;
    for (int k = 0; k <= limit; k++) begin
      @(negedge clk);
      if (k == 0) wr_en = 1'b0;
      if (bit_tick && first < 0) first = k;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedv, f, p, sel, n, unit, maxn;
    logic sm;
    seedv = $urandom(32'h5EED);
    rst_n = 1'b0; stby = 1'b0; sync_mode = 1'b0; src_sel = 2'd0;
    wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rate after reset", rd_data == 8'hFF, rd_data, 255);
    check("R1 bit tick low", bit_tick == 1'b0, bit_tick, 0);
    check("R1 ovs tick low", ovs_tick == 1'b0, ovs_tick, 0);
    check("R1 sclk edge low", sclk_edge == 1'b0, sclk_edge, 0);
    check("R1 sclk high", sclk == 1'b1, sclk, 1);

    // directed corners
    run_case(1'b0, 0, 0);
    run_case(1'b1, 0, 0);
    run_case(1'b1, 0, 255);
    run_case(1'b0, 1, 3);
    run_case(1'b1, 3, 2);
    run_case(1'b0, 2, 0);
    run_case(1'b1, 1, 7);

    // constrained random cases, periods kept to 2048 clocks or less
    for (int i = 0; i < 8; i++) begin
      sel  = int'($urandom % 4);
      sm   = logic'($urandom % 2);
      unit = (sm ? 4 : 32) * (1 << (2 * sel));
      maxn = 2048 / unit - 1;
      if (maxn > 255) maxn = 255;
      n = int'($urandom % (maxn + 1));
      run_case(sm, sel, n);
    end

    // R7 reload on source change alone
    run_case(1'b0, 0, 9);
    repeat (100) @(negedge clk);
    src_sel = 2'd1;
    p = bit_period(1'b0, 1, 9);
    wait_first(p + 4, f);
    check("R7 R3 reload on source change", f == p, f, p);

    // R7 reload on mode change alone
    repeat (37) @(negedge clk);
    sync_mode = 1'b1;
    p = bit_period(1'b1, 1, 9);
    wait_first(p + 4, f);
    check("R7 reload on mode change", f == p, f, p);

    // R7 rewrite of the same value mid period
    repeat (55) @(negedge clk);
    wr_data = 8'd9; wr_en = 1'b1;
    wait_first(p + 4, f);
    check("R7 reload on rewrite", f == p, f, p);

    // R8 standby
    repeat (21) @(negedge clk);
    sync_mode = 1'b1; src_sel = 2'd0;
    repeat (2) @(negedge clk);
    stby = 1'b1;
    @(negedge clk);
    check("R8 rate forced in standby", rd_data == 8'hFF, rd_data, 255);
    wr_data = 8'h12; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    begin
      int quiet_bad;
      quiet_bad = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (bit_tick || ovs_tick || sclk_edge || !sclk) quiet_bad++;
      end
      check("R8 no ticks in standby", quiet_bad == 0, quiet_bad, 0);
    end
    check("R8 write ignored in standby", rd_data == 8'hFF, rd_data, 255);
    stby = 1'b0;
    p = bit_period(1'b1, 0, 255);
    wait_first(p + 4, f);
    // iteration k lies k+1 edges after the last edge that sampled standby
    check("R8 first tick after standby", f + 1 == p, f + 1, p);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule